// File: doc/BRIEF.md
# Distributed Row Refresh Controller

This block keeps a square DRAM cell array alive by refreshing one row at a time, with the row refreshes spread evenly over the retention window instead of being gathered into a burst. A free-running interval timer raises a refresh demand every `INTERVAL` clock cycles. The default is 7812 cycles, which at 250 MHz spreads 256 rows over roughly 8 ms. A row address counter selects the next row. A refresh is a read-out of the whole row that writes the sensed contents straight back, so the stored values are restored and not changed.

Normal accesses reach the array through a valid/ready request channel. Each request carries a row, a column, a write flag and write data. A read returns one response beat on `rsp_valid`/`rsp_rdata`. The response channel has no ready: the consumer must always accept a response. On the request side, back-pressure is plain. A request is taken only on a cycle where `req_valid` and `req_ready` are both high. Until then the requester holds its request steady. `req_ready` is low while an access or a refresh is in progress, and also whenever a refresh is due, so a due refresh always wins over a waiting request at the next access boundary.

Top module: `dref_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `ref_row` is 0 and `ref_busy`, `ref_due` and `rsp_valid` are low. `req_ready` is high.
- R2: `ref_due` rises exactly once every `INTERVAL` cycles, whatever the access traffic is. With no access traffic, `ref_busy` also rises exactly every `INTERVAL` cycles.
- R3: While `ref_due` is high, `req_ready` is low. A request that is waiting when a refresh becomes due is accepted only after that refresh has finished.
- R4: Each refresh holds `ref_busy` high for exactly `REF_CYCLES` consecutive cycles, and `req_ready` stays low for all of them.
- R5: At the end of each refresh, `ref_row` advances by one, wrapping from `ROWS-1` to 0. At no other time does it change.
- R6: A write stores `req_wdata` in the cell at (`req_row`, `req_col`). A read returns the cell's current contents as a single-cycle `rsp_valid` pulse. Responses come back in request order, one for each read, and none for a write.
- R7: Refreshes never alter stored data. This includes the row being refreshed and data held across a full pass of all rows.
- R8: A due refresh starts at most `ACC_CYCLES`+1 cycles after `ref_due` rises, even under back-to-back request traffic.
- R9: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. A request held while `req_ready` is low produces exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address of the access |
| req_col | input | $clog2(ROWS) | Column address of the access |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata | output | DW | Read data |
| ref_due | output | 1 | A refresh is pending and not yet started |
| ref_busy | output | 1 | A row refresh is in progress |
| ref_row | output | $clog2(ROWS) | Next row to refresh |

## Verification
The checks assume that the parameters keep `INTERVAL` well above `REF_CYCLES` plus `ACC_CYCLES`. Under that assumption a new refresh demand never arrives while the previous one is still waiting, and the bench parameter set respects it. They also assume that a requester holds its fields stable until the request is taken, and that the response consumer never stalls. The bench driver raises a request on a falling edge and keeps it unchanged until it sees `req_ready` high. The bench never reads a cell it has not written, because unwritten cells have undefined contents.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_REF} dref_state_e;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_RESTORE} cell_op_e;
endpackage

// File: rtl/dref_timer.sv
module dref_timer #(
  parameter int INTERVAL = 7812
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic due
);
  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == LAST);

  // free-running: the demand spacing never depends on access traffic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due   <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       due <= 1'b1;
      else if (grant) due <= 1'b0;
    end
  end
endmodule

// File: rtl/dref_seq.sv
module dref_seq
  import dref_pkg::*;
#(
  parameter int ROWS       = 256,
  parameter int REF_CYCLES = 4,
  parameter int ACC_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    due,
  input  logic                    req_valid,
  output logic                    req_ready,
  output logic                    grant,
  output logic                    accept,
  output logic                    acc_done,
  output logic                    ref_done,
  output logic                    ref_busy,
  output logic [$clog2(ROWS)-1:0] ref_row
);
  localparam int RAW   = $clog2(ROWS);
  localparam int LONG  = (REF_CYCLES > ACC_CYCLES) ? REF_CYCLES : ACC_CYCLES;
  localparam int CW    = $clog2(LONG + 1);
  localparam logic [RAW-1:0] ROW_LAST = RAW'(ROWS - 1);

  dref_state_e    state_q;
  logic [CW-1:0]  cnt_q;
  logic           last;

  assign last      = (cnt_q == '0);
  assign req_ready = (state_q == ST_IDLE) && !due;
  assign grant     = (state_q == ST_IDLE) && due;
  assign accept    = req_valid && req_ready;
  assign acc_done  = (state_q == ST_ACC) && last;
  assign ref_done  = (state_q == ST_REF) && last;
  assign ref_busy  = (state_q == ST_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ref_row <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (grant) begin
            state_q <= ST_REF;
            cnt_q   <= CW'(REF_CYCLES - 1);
          end else if (accept) begin
            state_q <= ST_ACC;
            cnt_q   <= CW'(ACC_CYCLES - 1);
          end
        end
        ST_ACC, ST_REF: begin
          if (last) state_q <= ST_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (ref_done) ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/dref_cells.sv
module dref_cells
  import dref_pkg::*;
#(
  parameter int ROWS = 256,
  parameter int DW   = 1
) (
  input  logic                    clk,
  input  cell_op_e                op,
  input  logic [$clog2(ROWS)-1:0] row,
  input  logic [$clog2(ROWS)-1:0] col,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata
);
  localparam int LINE = ROWS * DW;

  logic [LINE-1:0] rows_q [ROWS];
  logic [LINE-1:0] sense;

  // a row is always sensed as a whole, as in the array
  assign sense = rows_q[row];

  always_ff @(posedge clk) begin
    unique case (op)
      OP_WRITE:   rows_q[row][col*DW +: DW] <= wdata;
      OP_READ:    rdata <= sense[col*DW +: DW];
      OP_RESTORE: rows_q[row] <= sense;
      default: ;
    endcase
  end
endmodule

// File: rtl/dref_ctrl.sv
module dref_ctrl
  import dref_pkg::*;
#(
  parameter int ROWS       = 256,
  parameter int DW         = 1,
  parameter int INTERVAL   = 7812,
  parameter int REF_CYCLES = 4,
  parameter int ACC_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [$clog2(ROWS)-1:0] req_row,
  input  logic [$clog2(ROWS)-1:0] req_col,
  input  logic [DW-1:0]           req_wdata,
  output logic                    rsp_valid,
  output logic [DW-1:0]           rsp_rdata,
  output logic                    ref_due,
  output logic                    ref_busy,
  output logic [$clog2(ROWS)-1:0] ref_row
);
  localparam int RAW = $clog2(ROWS);

  logic           grant, accept, acc_done, ref_done;
  logic           lat_write;
  logic [RAW-1:0] lat_row, lat_col, cell_row;
  logic [DW-1:0]  lat_wdata;
  cell_op_e       op;

  dref_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .grant(grant), .due(ref_due)
  );

  dref_seq #(.ROWS(ROWS), .REF_CYCLES(REF_CYCLES), .ACC_CYCLES(ACC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .due(ref_due), .req_valid(req_valid),
    .req_ready(req_ready), .grant(grant), .accept(accept),
    .acc_done(acc_done), .ref_done(ref_done), .ref_busy(ref_busy),
    .ref_row(ref_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wdata <= '0;
      rsp_valid <= 1'b0;
    end else begin
      if (accept) begin
        lat_write <= req_write;
        lat_row   <= req_row;
        lat_col   <= req_col;
        lat_wdata <= req_wdata;
      end
      rsp_valid <= acc_done && !lat_write;
    end
  end

  always_comb begin
    op       = OP_NONE;
    cell_row = lat_row;
    if (acc_done) begin
      op = lat_write ? OP_WRITE : OP_READ;
    end else if (ref_done) begin
      op       = OP_RESTORE;
      cell_row = ref_row;
    end
  end

  dref_cells #(.ROWS(ROWS), .DW(DW)) u_cells (
    .clk(clk), .op(op), .row(cell_row), .col(lat_col),
    .wdata(lat_wdata), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/dref_ctrl_chk.sv
module dref_ctrl_chk #(
  parameter int ROWS       = 256,
  parameter int INTERVAL   = 7812,
  parameter int REF_CYCLES = 4,
  parameter int ACC_CYCLES = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic                    ref_due,
  input logic                    ref_busy,
  input logic [$clog2(ROWS)-1:0] ref_row,
  input logic                    rsp_valid
);
  localparam int RAW = $clog2(ROWS);
  localparam int GW  = $clog2(INTERVAL + 2) + 1;
  localparam int BW  = $clog2(REF_CYCLES + 2) + 1;
  localparam int DWW = $clog2(ACC_CYCLES + 4) + 1;

  logic [GW-1:0]  gap_q;
  logic           seen_q, due_prev_q;
  logic [BW-1:0]  busy_len_q;
  logic [DWW-1:0] due_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q      <= '0;
      seen_q     <= 1'b0;
      due_prev_q <= 1'b0;
      busy_len_q <= '0;
      due_len_q  <= '0;
    end else begin
      due_prev_q <= ref_due;
      if (ref_due && !due_prev_q) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      busy_len_q <= ref_busy ? ((busy_len_q != '1) ? busy_len_q + 1'b1 : busy_len_q) : '0;
      due_len_q  <= ref_due  ? ((due_len_q  != '1) ? due_len_q  + 1'b1 : due_len_q)  : '0;
    end
  end

  // R2
  due_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_due && !due_prev_q && seen_q) |-> gap_q == GW'(INTERVAL));
  // R3
  due_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_due |-> !req_ready);
  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !req_ready);
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> busy_len_q == BW'(REF_CYCLES));
  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ref_busy) |-> ref_row == (($past(ref_row) == RAW'(ROWS - 1)) ? '0 : $past(ref_row) + 1'b1));
  // R5
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ref_busy) |-> $stable(ref_row));
  // R6
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R8
  due_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    due_len_q <= DWW'(ACC_CYCLES + 1));
endmodule

bind dref_ctrl dref_ctrl_chk #(
  .ROWS(ROWS), .INTERVAL(INTERVAL), .REF_CYCLES(REF_CYCLES), .ACC_CYCLES(ACC_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_due(ref_due),
  .ref_busy(ref_busy), .ref_row(ref_row), .rsp_valid(rsp_valid)
);

// File: tb/sim_dref_ctrl.sv
module sim_dref_ctrl;
  localparam int ROWS  = 256;
  localparam int DW    = 4;
  localparam int IVL   = 40;
  localparam int REFC  = 4;
  localparam int ACCC  = 2;
  localparam int RAW   = $clog2(ROWS);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0;
  logic           req_write = 1'b0;
  logic [RAW-1:0] req_row = '0;
  logic [RAW-1:0] req_col = '0;
  logic [DW-1:0]  req_wdata = '0;
  logic           req_ready, rsp_valid, ref_due, ref_busy;
  logic [DW-1:0]  rsp_rdata;
  logic [RAW-1:0] ref_row;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int reads_sent = 0;
  int rsps_seen = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] bm[int];

  // monitor state
  bit prev_busy = 0, prev_due = 0;
  int blen = 0, dlen = 0;
  int busy_rise_cyc = -1, due_rise_cyc = -1;
  logic [RAW-1:0] row_at_rise = '0;
  bit spac = 0, wrap_seen = 0;
  int spac_rises = 0;
  bit ready_in_busy = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dref_ctrl #(.ROWS(ROWS), .DW(DW), .INTERVAL(IVL), .REF_CYCLES(REFC), .ACC_CYCLES(ACCC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ref_due(ref_due),
    .ref_busy(ref_busy), .ref_row(ref_row)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: raises the request on a falling edge, holds until ready (R9)
  task automatic do_req(input bit w, input int row, input int col, input int d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_row   = RAW'(row);
    req_col   = RAW'(col);
    req_wdata = DW'(d);
    while (!req_ready) @(negedge clk);
    if (w) bm[row*ROWS+col] = DW'(d);
    else begin
      exp_q.push_back(bm[row*ROWS+col]);
      reads_sent++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // scoreboard monitor and refresh observers
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_valid) begin
        rsps_seen++;
        if (exp_q.size() == 0) check(0, "R6 unexpected response", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rsp_rdata === e, "R6/R7 read data", int'(rsp_rdata), int'(e));
        end
      end
      // R3: due blocks ready; R8: bounded wait
      if (ref_due) begin
        dlen++;
        if (req_ready) check(0, "R3 ready while due", 1, 0);
        if (!prev_due) begin
          if (due_rise_cyc >= 0) check(cyc - due_rise_cyc == IVL, "R2 due spacing", cyc - due_rise_cyc, IVL);
          due_rise_cyc = cyc;
        end
      end else if (prev_due) begin
        check(dlen <= ACCC + 1, "R8 due wait", dlen, ACCC + 1);
        dlen = 0;
      end
      // R4 / R5 / R2 on refresh pulses
      if (ref_busy) begin
        if (!prev_busy) begin
          row_at_rise = ref_row;
          ready_in_busy = 0;
          if (spac) begin
            if (busy_rise_cyc >= 0) check(cyc - busy_rise_cyc == IVL, "R2 idle refresh spacing", cyc - busy_rise_cyc, IVL);
            busy_rise_cyc = cyc;
            spac_rises++;
          end
        end
        blen++;
        if (req_ready) ready_in_busy = 1;
      end else if (prev_busy) begin
        check(blen == REFC, "R4 refresh length", blen, REFC);
        check(!ready_in_busy, "R4 ready during refresh", int'(ready_in_busy), 0);
        check(int'(ref_row) == (int'(row_at_rise) + 1) % ROWS, "R5 row advance", int'(ref_row), (int'(row_at_rise) + 1) % ROWS);
        if (row_at_rise == RAW'(ROWS - 1) && ref_row == '0) wrap_seen = 1;
        blen = 0;
      end
      prev_busy = ref_busy;
      prev_due  = ref_due;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int tgt;
    repeat (5) @(negedge clk);
    // R1: reset values while asserted
    check(req_ready === 1'b1 && ref_busy === 1'b0 && ref_due === 1'b0 && rsp_valid === 1'b0 && ref_row === '0,
          "R1 reset outputs", int'({req_ready, ref_busy, ref_due, rsp_valid}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && ref_row === '0 && !ref_busy, "R1 after release", int'(ref_row), 0);

    // R2: idle spacing of refreshes
    busy_rise_cyc = -1;
    spac = 1;
    while (spac_rises < 4) @(negedge clk);
    spac = 0;

    // R6: writes then reads, several patterns
    for (int i = 0; i < 16; i++) do_req(1, (i * 17) % ROWS, (i * 29 + 3) % ROWS, i);
    for (int i = 0; i < 16; i++) do_req(0, (i * 17) % ROWS, (i * 29 + 3) % ROWS, 0);
    do_req(1, 5, 5, 4'hA);
    do_req(0, 5, 5, 0);
    do_req(1, 5, 5, 4'h5);
    do_req(0, 5, 5, 0);
    do_req(1, ROWS - 1, ROWS - 1, 4'hF);
    do_req(0, ROWS - 1, ROWS - 1, 0);

    // R7: write into the rows about to be refreshed, read after they are refreshed
    tgt = (int'(ref_row) + 1) % ROWS;
    for (int c = 0; c < 4; c++) do_req(1, tgt, c * 60, 4'h9 ^ c);
    do_req(1, (tgt + 1) % ROWS, 7, 4'h6);
    repeat (3 * IVL) @(negedge clk);
    for (int c = 0; c < 4; c++) do_req(0, tgt, c * 60, 0);
    do_req(0, (tgt + 1) % ROWS, 7, 0);

    // R3/R8/R9: back-to-back traffic across several refresh demands
    for (int i = 0; i < 60; i++) do_req(i % 3 == 0, (i * 7) % ROWS, (i * 11) % ROWS, i);

    // R5: full pass of every row, wrap must be observed
    repeat (ROWS * IVL + 2 * IVL) @(negedge clk);
    check(wrap_seen, "R5 wrap to row 0", int'(wrap_seen), 1);

    // R7: data retained across a full refresh pass
    for (int i = 0; i < 16; i++) do_req(0, (i * 17) % ROWS, (i * 29 + 3) % ROWS, 0);
    do_req(0, ROWS - 1, ROWS - 1, 0);

    for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
    check(rsps_seen == reads_sent, "R9 one access per request", rsps_seen, reads_sent);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule